// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine

This engine moves sector data for a disk-style device between the device's word stream and system memory. Software builds a table of 8-byte region descriptors in memory, loads the table's base address into a byte-wide register port, chooses a direction, and sets the start bit. The engine then reads the table one descriptor at a time, 32-bit word by 32-bit word, and moves each region in turn. A `last` flag on the device side marks the final word of the device's transfer.

When the transfer ends, the status register shows one of three outcomes. The table and the device data can end together. The table can run out while the device still has data. The device can finish while the table still has room. Software can abort a transfer by clearing the start bit, and the result differs with the outcome. An error response from memory stops the engine and sets the error flag.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. The register offsets are: 0 = command, 2 = status, 4..7 = table pointer (byte 4 is least significant). Any other offset reads 0.
- R2: Writing command bit 0 = 1 while the start bit is 0 and the engine is not active sets status bit 0 (active). The engine then fetches descriptors starting at the table pointer. A descriptor is two little-endian 32-bit words: first the buffer address, then the control word. The control word holds the byte count in bits 15:0 (a multiple of 4) and the end-of-table flag in bit 31.
- R3: Command bit 3 = 1 moves device words into memory as memory writes. Command bit 3 = 0 reads memory and sends the words to the device. The device-side read handshake and write handshake are never active at the same time.
- R4: If the device's last word also uses up the last byte of the end-of-table descriptor, status becomes active = 0 and interrupt (bit 2) = 1, and `irq_o` goes high.
- R5: If the end-of-table descriptor is used up and the word that used it up did not carry `last`, status becomes active = 0 and interrupt = 0 (table too short).
- R6: If `last` arrives while descriptor space remains, status becomes active = 1 and interrupt = 1, and no further memory or device beats take place. A later write of command 0 leaves only interrupt set.
- R7: Writing command bit 0 = 0 while a transfer runs clears active at once. Interrupt stays as it was, and no further memory requests or device beats follow.
- R8: Writing 1 to status bit 2 clears interrupt and lowers `irq_o`. Writing 1 to status bit 1 clears error. Writing 0 to these bits has no effect.
- R9: A write to the table pointer while active is ignored. The same write while idle takes effect.
- R10: An error response from memory sets status bit 1 (error), clears active and stops the engine. Interrupt is left unchanged.
- R11: When a descriptor without the end-of-table flag is used up, the engine fetches the next descriptor 8 bytes further on and continues the data in order.
- R12: A byte count field of 0 means 65536 bytes.
- R13: A memory request holds its address and direction stable until `mem_ack_i` is high, unless the transfer is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt, equal to status bit 2 |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory response for the current request |
| mem_err_i | input | 1 | Error response, valid with `mem_ack_i` |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |
| dev_rd_valid_i | input | 1 | Device offers a word (device to memory) |
| dev_rd_data_i | input | 32 | Word from the device |
| dev_rd_ready_o | output | 1 | Engine takes the offered word |
| dev_wr_valid_o | output | 1 | Engine offers a word to the device |
| dev_wr_data_o | output | 32 | Word to the device |
| dev_wr_ready_i | input | 1 | Device takes the offered word |
| dev_last_i | input | 1 | Qualifies the current device beat as the device's final word |

## Verification
The hardest case to reach is the "too long" hold. In it the device ends early, and the engine must stay active with its interrupt raised and issue no more traffic until software clears the start bit. The stimulus has a device model that raises `last` well before the table runs out. One such case uses a zero byte count, which stands for 65536 bytes. The bench then watches a memory-request counter and the status register over a quiet interval before it writes the stop. An abort in the middle of a sector-sized transfer gets the same quiet-interval treatment. An error from the memory model is injected on a chosen address.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int WORD_W     = 32;
  localparam int BEAT_BYTES = WORD_W / 8;
  localparam int DESC_BYTES = 8;
  localparam int OFF_CMD    = 0;
  localparam int OFF_STS    = 2;
  localparam int OFF_PTR    = 4;
  localparam int CMD_GO     = 0;
  localparam int CMD_D2M    = 3;
  localparam int STS_ACT    = 0;
  localparam int STS_ERR    = 1;
  localparam int STS_INT    = 2;
  localparam int DESC_LAST  = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FET_A, ST_FET_C, ST_RD_MEM, ST_WR_DEV, ST_RD_DEV, ST_WR_MEM, ST_HOLD
  } seq_st_e;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RA_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              ev_ok_i,
  input  logic              ev_short_i,
  input  logic              ev_err_i,
  input  logic              ev_hold_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              active_o,
  output logic              err_o,
  output logic              intr_o
);
  localparam int NBYTES = ADDR_W / 8;

  logic go_q, dir_q, act_q, err_q, int_q;
  logic [ADDR_W-1:0] ptr_q;
  logic cmd_wr, sts_wr;

  assign cmd_wr  = we_i && (int'(addr_i) == OFF_CMD);
  assign sts_wr  = we_i && (int'(addr_i) == OFF_STS);
  assign start_o = cmd_wr && wdata_i[CMD_GO] && !go_q && !act_q;
  assign stop_o  = cmd_wr && !wdata_i[CMD_GO] && go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q  <= 1'b0;
      dir_q <= 1'b0;
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      if (cmd_wr) begin
        go_q <= wdata_i[CMD_GO];
        if (!act_q) dir_q <= wdata_i[CMD_D2M];
      end
      if (start_o) act_q <= 1'b1;
      else if (stop_o || ev_ok_i || ev_short_i || ev_err_i) act_q <= 1'b0;
      // set events win over a same-cycle clear
      if (ev_ok_i || ev_hold_i) int_q <= 1'b1;
      else if (sts_wr && wdata_i[STS_INT]) int_q <= 1'b0;
      if (ev_err_i) err_q <= 1'b1;
      else if (sts_wr && wdata_i[STS_ERR]) err_q <= 1'b0;
      if (we_i && !act_q) begin
        for (int b = 0; b < NBYTES; b++) begin
          if (int'(addr_i) == OFF_PTR + b) ptr_q[8*b +: 8] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) == OFF_CMD) begin
      rdata_o[CMD_GO]  = go_q;
      rdata_o[CMD_D2M] = dir_q;
    end
    if (int'(addr_i) == OFF_STS) begin
      rdata_o[STS_ACT] = act_q;
      rdata_o[STS_ERR] = err_q;
      rdata_o[STS_INT] = int_q;
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (int'(addr_i) == OFF_PTR + b) rdata_o = ptr_q[8*b +: 8];
    end
  end

  assign dir_o    = dir_q;
  assign ptr_o    = ptr_q;
  assign active_o = act_q;
  assign err_o    = err_q;
  assign intr_o   = int_q;
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              dev_rd_valid_i,
  input  logic [WORD_W-1:0] dev_rd_data_i,
  output logic              dev_rd_ready_o,
  output logic              dev_wr_valid_o,
  output logic [WORD_W-1:0] dev_wr_data_o,
  input  logic              dev_wr_ready_i,
  input  logic              dev_last_i,
  output logic              ev_ok_o,
  output logic              ev_short_o,
  output logic              ev_err_o,
  output logic              ev_hold_o
);
  localparam logic [CNT_W:0] CNT_FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] CNT_STEP = (CNT_W+1)'(BEAT_BYTES);

  seq_st_e st_q;
  logic [ADDR_W-1:0] dptr_q, baddr_q;
  logic [CNT_W:0]    cnt_q, cnt_n;
  logic [WORD_W-1:0] data_q;
  logic eot_q, last_q;
  logic beat_fire, beat_last, desc_end, run_ok;
  logic unused_rdata;

  assign unused_rdata = ^mem_rdata_i[DESC_LAST-1:CNT_W];

  always_comb begin
    mem_req_o  = (st_q == ST_FET_A) || (st_q == ST_FET_C) ||
                 (st_q == ST_RD_MEM) || (st_q == ST_WR_MEM);
    mem_we_o   = (st_q == ST_WR_MEM);
    mem_addr_o = baddr_q;
    if (st_q == ST_FET_A) mem_addr_o = dptr_q;
    if (st_q == ST_FET_C) mem_addr_o = dptr_q + ADDR_W'(BEAT_BYTES);
    dev_rd_ready_o = (st_q == ST_RD_DEV);
    dev_wr_valid_o = (st_q == ST_WR_DEV);
    run_ok    = !stop_i;
    beat_fire = ((st_q == ST_WR_DEV) && dev_wr_ready_i) ||
                ((st_q == ST_WR_MEM) && mem_ack_i && !mem_err_i);
    beat_last = (st_q == ST_WR_DEV) ? dev_last_i : last_q;
    cnt_n     = cnt_q - CNT_STEP;
    desc_end  = (cnt_n == '0);
    ev_err_o   = run_ok && mem_req_o && mem_ack_i && mem_err_i;
    ev_ok_o    = run_ok && beat_fire && beat_last && desc_end && eot_q;
    ev_hold_o  = run_ok && beat_fire && beat_last && !(desc_end && eot_q);
    ev_short_o = run_ok && beat_fire && !beat_last && desc_end && eot_q;
  end

  assign mem_wdata_o   = data_q;
  assign dev_wr_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dptr_q  <= '0;
      baddr_q <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      eot_q   <= 1'b0;
      last_q  <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else if (ev_err_o) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          dptr_q <= ptr_i;
          st_q   <= ST_FET_A;
        end
        ST_FET_A: if (mem_ack_i) begin
          baddr_q <= mem_rdata_i[ADDR_W-1:0];
          st_q    <= ST_FET_C;
        end
        ST_FET_C: if (mem_ack_i) begin
          cnt_q <= (mem_rdata_i[CNT_W-1:0] == '0) ? CNT_FULL
                                                  : {1'b0, mem_rdata_i[CNT_W-1:0]};
          eot_q <= mem_rdata_i[DESC_LAST];
          st_q  <= dir_i ? ST_RD_DEV : ST_RD_MEM;
        end
        ST_RD_MEM: if (mem_ack_i) begin
          data_q <= mem_rdata_i;
          st_q   <= ST_WR_DEV;
        end
        ST_RD_DEV: if (dev_rd_valid_i) begin
          data_q <= dev_rd_data_i;
          last_q <= dev_last_i;
          st_q   <= ST_WR_MEM;
        end
        ST_HOLD: ;
        default: ;
      endcase
      if (beat_fire) begin
        cnt_q   <= cnt_n;
        baddr_q <= baddr_q + ADDR_W'(BEAT_BYTES);
        if (beat_last)      st_q <= (desc_end && eot_q) ? ST_IDLE : ST_HOLD;
        else if (!desc_end) st_q <= dir_i ? ST_RD_DEV : ST_RD_MEM;
        else if (eot_q)     st_q <= ST_IDLE;
        else begin
          dptr_q <= dptr_q + ADDR_W'(DESC_BYTES);
          st_q   <= ST_FET_A;
        end
      end
    end
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int RA_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              dev_rd_valid_i,
  input  logic [WORD_W-1:0] dev_rd_data_i,
  output logic              dev_rd_ready_o,
  output logic              dev_wr_valid_o,
  output logic [WORD_W-1:0] dev_wr_data_o,
  input  logic              dev_wr_ready_i,
  input  logic              dev_last_i
);
  logic start_w, stop_w, dir_w, active_w, err_w, intr_w;
  logic ev_ok_w, ev_short_w, ev_err_w, ev_hold_w;
  logic [ADDR_W-1:0] ptr_w;

  bmdma_regs #(.ADDR_W(ADDR_W), .RA_W(RA_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ev_ok_i(ev_ok_w), .ev_short_i(ev_short_w), .ev_err_i(ev_err_w), .ev_hold_i(ev_hold_w),
    .start_o(start_w), .stop_o(stop_w), .dir_o(dir_w), .ptr_o(ptr_w),
    .active_o(active_w), .err_o(err_w), .intr_o(intr_w)
  );

  bmdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i(start_w), .stop_i(stop_w), .dir_i(dir_w), .ptr_i(ptr_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .dev_rd_valid_i, .dev_rd_data_i, .dev_rd_ready_o,
    .dev_wr_valid_o, .dev_wr_data_o, .dev_wr_ready_i, .dev_last_i,
    .ev_ok_o(ev_ok_w), .ev_short_o(ev_short_w), .ev_err_o(ev_err_w), .ev_hold_o(ev_hold_w)
  );

  assign irq_o = intr_w;
endmodule

// File: rtl/bmdma_checks.sv
module bmdma_checks #(
  parameter int ADDR_W = 32,
  parameter int RA_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic              dev_rd_ready_o,
  input logic              dev_wr_valid_o,
  input logic              active_w,
  input logic              err_w,
  input logic              stop_w,
  input logic [ADDR_W-1:0] ptr_w
);
  p_ptr_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_w && reg_we_i && reg_addr_i[2]) |=> $stable(ptr_w));

  p_req_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !stop_w) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_req_when_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> active_w);

  p_abort_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (!active_w && !mem_req_o && !dev_rd_ready_o && !dev_wr_valid_o));

  p_err_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i && !stop_w) |=> (!active_w && err_w));

  p_one_side_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_rd_ready_o, dev_wr_valid_o}));
endmodule

bind bmdma_engine bmdma_checks #(.ADDR_W(ADDR_W), .RA_W(RA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
  .dev_rd_ready_o(dev_rd_ready_o), .dev_wr_valid_o(dev_wr_valid_o),
  .active_w(active_w), .err_w(err_w), .stop_w(stop_w), .ptr_w(ptr_w)
);

// File: tb/test_bmdma_engine.sv
module test_bmdma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        irq;
  logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rd_valid, rd_ready, wr_valid, wr_ready, dev_last;
  logic [31:0] rd_data, wr_data;

  bmdma_engine i_bmdma_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .dev_rd_valid_i(rd_valid), .dev_rd_data_i(rd_data), .dev_rd_ready_o(rd_ready),
    .dev_wr_valid_o(wr_valid), .dev_wr_data_o(wr_data), .dev_wr_ready_i(wr_ready),
    .dev_last_i(dev_last)
  );

  // memory model: one response per request, one idle cycle between
  logic [31:0] mem [1024];
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          req_cnt = 0;
  always @(posedge clk) begin
    if (mem_req) req_cnt <= req_cnt + 1;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_err   <= err_en && (mem_addr == err_addr);
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we && !(err_en && (mem_addr == err_addr))) mem[mem_addr[11:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  // device models
  logic        d2m = 1'b0;
  int          src_len = 0, src_cnt = 0, snk_len = 0, snk_cnt = 0;
  logic [31:0] snk_buf [256];
  assign rd_valid = src_cnt < src_len;
  assign rd_data  = 32'hA500_0000 + src_cnt;
  assign wr_ready = snk_cnt < snk_len;
  assign dev_last = d2m ? (src_cnt == src_len - 1) : (snk_cnt == snk_len - 1);
  always @(posedge clk) begin
    if (rd_valid && rd_ready) src_cnt <= src_cnt + 1;
    if (wr_valid && wr_ready) begin
      snk_buf[snk_cnt[7:0]] <= wr_data;
      snk_cnt <= snk_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ptr(logic [31:0] p);
    for (int b = 0; b < 4; b++) wr(3'(4 + b), p[8*b +: 8]);
  endtask

  task automatic rd_ptr(output logic [31:0] p);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin rd(3'(4 + b), d); p[8*b +: 8] = d; end
  endtask

  task automatic desc(int at, logic [31:0] buf_a, logic [15:0] cnt, bit eot);
    mem[at/4]     = buf_a;
    mem[at/4 + 1] = {eot, 15'd0, cnt};
  endtask

  task automatic launch(logic [31:0] tbl, bit to_mem, int src, int snk);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h06);
    set_ptr(tbl);
    d2m = to_mem; src_cnt = 0; src_len = src; snk_cnt = 0; snk_len = snk;
    wr(3'd0, {4'b0, to_mem, 3'b001});
  endtask

  task automatic wait_end(output logic [7:0] s);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(3'd2, s);
      if (!s[0] || s[2]) break;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [31:0] p;
    rd(3'd0, d); check("R1 cmd reset", d, 0);
    rd(3'd2, d); check("R1 status reset", d, 0);
    rd_ptr(p);   check("R1 ptr reset", p, 0);
    check("R1 irq reset", irq, 0);
    set_ptr(32'h1234_5670);
    rd_ptr(p);   check("R9 ptr write while idle", p, 32'h1234_5670);
  endtask

  task automatic t_exact_d2m;
    logic [7:0] s; bit ok = 1;
    desc(32'h000, 32'h100, 16'd16, 1);
    launch(32'h000, 1, 4, 0);
    wait_end(s);
    check("R4 exact status", s, 8'h04);
    check("R4 irq high", irq, 1);
    for (int i = 0; i < 4; i++) if (mem[64 + i] !== 32'hA500_0000 + i) ok = 0;
    check("R3 R2 data written to descriptor buffer", ok, 1);
    wr(3'd2, 8'h00);
    rd(3'd2, s); check("R8 write zero keeps intr", s, 8'h04);
    wr(3'd2, 8'h04);
    rd(3'd2, s); check("R8 intr cleared", s, 8'h00);
    check("R8 irq low", irq, 0);
  endtask

  task automatic t_short_m2d;
    logic [7:0] s; bit ok = 1;
    for (int i = 0; i < 128; i++) mem[256 + i] = 32'h5500_0000 + i;
    desc(32'h010, 32'h400, 16'd512, 1);
    launch(32'h010, 0, 0, 256);
    wait_end(s);
    check("R5 short status", s, 8'h00);
    check("R5 words sent", snk_cnt, 128);
    for (int i = 0; i < 128; i++) if (snk_buf[i] !== 32'h5500_0000 + i) ok = 0;
    check("R3 read data order", ok, 1);
  endtask

  task automatic t_long_d2m;
    logic [7:0] s; logic [31:0] p; int r0;
    desc(32'h020, 32'h200, 16'd64, 1);
    launch(32'h020, 1, 8, 0);
    wait_end(s);
    check("R6 long status", s, 8'h05);
    r0 = req_cnt;
    set_ptr(32'hDEAD_BEE0);
    rd_ptr(p); check("R9 ptr write ignored while active", p, 32'h0000_0020);
    repeat (40) @(negedge clk);
    check("R6 no memory traffic in hold", req_cnt, r0);
    rd(3'd2, s); check("R6 hold persists", s, 8'h05);
    wr(3'd0, 8'h00);
    rd(3'd2, s); check("R6 stop leaves intr only", s, 8'h04);
  endtask

  task automatic t_chain_m2d;
    logic [7:0] s;
    mem[128] = 32'h11; mem[129] = 32'h22; mem[192] = 32'h33; mem[193] = 32'h44;
    desc(32'h030, 32'h200, 16'd8, 0);
    desc(32'h038, 32'h300, 16'd8, 1);
    launch(32'h030, 0, 0, 4);
    wait_end(s);
    check("R11 chained exact status", s, 8'h04);
    check("R11 chain word 0", snk_buf[0], 32'h11);
    check("R11 chain word 2", snk_buf[2], 32'h33);
    check("R11 chain word 3", snk_buf[3], 32'h44);
  endtask

  task automatic t_zero_count;
    logic [7:0] s;
    desc(32'h040, 32'h800, 16'd0, 1);
    launch(32'h040, 1, 4, 0);
    wait_end(s);
    check("R12 zero count is 65536 so table too long", s, 8'h05);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] s; int r0, c0;
    desc(32'h048, 32'h400, 16'd512, 1);
    launch(32'h048, 1, 1000, 0);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd2, s); check("R7 abort status", s, 8'h00);
    r0 = req_cnt; c0 = src_cnt;
    repeat (40) @(negedge clk);
    check("R7 no memory requests after abort", req_cnt, r0);
    check("R7 no device beats after abort", src_cnt, c0);
  endtask

  task automatic t_mem_err;
    logic [7:0] s;
    desc(32'h050, 32'h100, 16'd16, 1);
    err_en = 1; err_addr = 32'h054;
    launch(32'h050, 1, 4, 0);
    wait_end(s);
    err_en = 0;
    check("R10 error status", s, 8'h02);
    check("R10 no device beat taken", src_cnt, 0);
    wr(3'd2, 8'h02);
    rd(3'd2, s); check("R8 error cleared", s, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_exact_d2m;
    t_short_m2d;
    t_long_d2m;
    t_chain_m2d;
    t_zero_count;
    t_abort;
    t_mem_err;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule